// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps track of which lanes of a 32-lane single-instruction multiple-thread processor are allowed to commit results while the instruction stream passes through nested if/else regions. Every lane steps through both sides of a branch. The block's output mask only decides which lanes write back.

The controller drives three events. The branch event saves the current mask on a bounded stack and narrows the mask to the lanes whose predicate bit is set. The else event switches to the opposite side of the innermost branch, using the saved mask so that lanes that were idle before the branch stay idle. The join event restores the saved mask at the reconvergence point.

A push into a full stack and a pop or else on an empty stack are both rejected and flagged. A separate flag reports an all-zero mask, so the controller can skip a path that no lane will commit.

Top module: `simt_mask_stack`

## Requirements
- R1: After synchronous active-low reset the mask is all ones, the stack is empty, and both error flags and the idle flag are low.
- R2: An accepted branch event saves the current mask as the new stack top and sets the mask to the current mask ANDed with the lane predicate.
- R3: An accepted else event sets the mask to the stack top ANDed with the inverse of the current mask, and leaves the stack unchanged. A second else event returns to the first side.
- R4: An accepted join event sets the mask to the stack top and removes that entry.
- R5: A branch event while the stack holds DEPTH entries sets the overflow flag and leaves both the mask and the stack unchanged.
- R6: An else or join event while the stack is empty sets the underflow flag and leaves the mask unchanged.
- R7: Each error flag is registered. It is high for exactly the one cycle after the rejected event and low in every other cycle.
- R8: The idle flag is high in the same cycle in which the mask is all zeros, and low otherwise.
- R9: When several events are raised in one cycle, only the branch event acts if it is present. Otherwise only the else event acts.
- R10: A lane whose mask bit was clear before a branch event stays clear through that branch, its else event and any nested branches, until the matching join.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_push_i | input | 1 | Divergent-branch event |
| br_flip_i | input | 1 | Else-point event |
| br_join_i | input | 1 | Reconvergence event |
| lane_pred_i | input | LANES | Per-lane predicate bits, sampled with the branch event |
| lane_mask_o | output | LANES | Current commit mask |
| mask_idle_o | output | 1 | Mask is all zeros |
| stack_ovf_o | output | 1 | Branch event rejected, stack full |
| stack_udf_o | output | 1 | Else or join event rejected, stack empty |

## Verification
The bench builds the block with the default 32 lanes and a stack depth of 4. The shallow stack puts the full-stack and empty-stack rejections within a handful of events, so random event streams run into both rejections many times. It also reaches nested flips several levels deep. With 32 lanes, random predicates rarely clear the whole mask, so directed sequences with all-zero and complementary predicates drive the idle flag.

// File: rtl/simt_mask_pkg.sv
// Shared types for the divergence mask stack.
// Assumes: only one event is acted on per cycle.
package simt_mask_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_PUSH = 2'd1,
        EV_FLIP = 2'd2,
        EV_POP  = 2'd3
    } mask_ev_e;
endpackage

// File: rtl/mask_evt_decode.sv
// Reduces the three raw control strobes to one event, branch first, then else,
// then join. Assumes strobes are single-cycle and synchronous to the clock.
module mask_evt_decode
    import simt_mask_pkg::*;
(
    input  logic     push_i,
    input  logic     flip_i,
    input  logic     pop_i,
    output mask_ev_e ev_o
);
    // Fixed-priority selection of the single event to act on.
    always_comb begin
        if (push_i)      ev_o = EV_PUSH;
        else if (flip_i) ev_o = EV_FLIP;
        else if (pop_i)  ev_o = EV_POP;
        else             ev_o = EV_NONE;
    end
endmodule

// File: rtl/mask_lifo.sv
// Bounded last-in first-out store of lane masks.
// Assumes the caller never pushes when full or pops when empty.
module mask_lifo #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] push_data_i,
    output logic [LANES-1:0] top_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int LVLW = $clog2(DEPTH + 1);

    logic [LVLW-1:0]  level_q;
    logic [LANES-1:0] entry_q [DEPTH];

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= '0;
        else if (push_i) level_q <= level_q + LVLW'(1);
        else if (pop_i)  level_q <= level_q - LVLW'(1);
    end

    // One register per slot, written when it is the next free slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                entry_q[g] <= '0;
            else if (push_i && level_q == LVLW'(g))    entry_q[g] <= push_data_i;
        end
    end

    // Select the most recently written slot.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (level_q == LVLW'(i + 1)) top_o = entry_q[i];
    end

    assign full_o  = (level_q == LVLW'(DEPTH));
    assign empty_o = (level_q == '0);

    // R4
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> level_q == $past(level_q) - LVLW'(1));

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_data_i));
endmodule

// File: rtl/mask_update.sv
// Computes the next lane mask and the accept/reject decisions for one event.
// Assumes top_i is meaningful only when empty_i is low.
module mask_update
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  mask_ev_e         ev_i,
    input  logic [LANES-1:0] cur_i,
    input  logic [LANES-1:0] top_i,
    input  logic [LANES-1:0] pred_i,
    input  logic             full_i,
    input  logic             empty_i,
    output logic [LANES-1:0] nxt_o,
    output logic             do_push_o,
    output logic             do_pop_o,
    output logic             ovf_o,
    output logic             udf_o
);
    // Event handling: narrow, flip, restore or reject.
    always_comb begin
        nxt_o     = cur_i;
        do_push_o = 1'b0;
        do_pop_o  = 1'b0;
        ovf_o     = 1'b0;
        udf_o     = 1'b0;
        unique case (ev_i)
            EV_PUSH: begin
                if (full_i) ovf_o = 1'b1;
                else begin
                    do_push_o = 1'b1;
                    nxt_o     = cur_i & pred_i;
                end
            end
            EV_FLIP: begin
                if (empty_i) udf_o = 1'b1;
                else         nxt_o = top_i & ~cur_i;
            end
            EV_POP: begin
                if (empty_i) udf_o = 1'b1;
                else begin
                    do_pop_o = 1'b1;
                    nxt_o    = top_i;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simt_mask_stack.sv
// Active-lane mask controller for nested divergent branches.
// Holds the current mask, a stack of saved masks and registered error pulses.
// Assumes events arrive one per instruction boundary.
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_push_i,
    input  logic             br_flip_i,
    input  logic             br_join_i,
    input  logic [LANES-1:0] lane_pred_i,
    output logic [LANES-1:0] lane_mask_o,
    output logic             mask_idle_o,
    output logic             stack_ovf_o,
    output logic             stack_udf_o
);
    mask_ev_e         ev;
    logic [LANES-1:0] top, nxt;
    logic             full, empty, do_push, do_pop, ovf, udf;
    logic [LANES-1:0] mask_q;

    mask_evt_decode u_dec (
        .push_i (br_push_i),
        .flip_i (br_flip_i),
        .pop_i  (br_join_i),
        .ev_o   (ev)
    );

    mask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) u_lifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (do_push),
        .pop_i       (do_pop),
        .push_data_i (mask_q),
        .top_o       (top),
        .full_o      (full),
        .empty_o     (empty)
    );

    mask_update #(.LANES(LANES)) u_upd (
        .ev_i      (ev),
        .cur_i     (mask_q),
        .top_i     (top),
        .pred_i    (lane_pred_i),
        .full_i    (full),
        .empty_i   (empty),
        .nxt_o     (nxt),
        .do_push_o (do_push),
        .do_pop_o  (do_pop),
        .ovf_o     (ovf),
        .udf_o     (udf)
    );

    // Current mask register, all lanes enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= nxt;
    end

    // One-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stack_ovf_o <= 1'b0;
            stack_udf_o <= 1'b0;
        end else begin
            stack_ovf_o <= ovf;
            stack_udf_o <= udf;
        end
    end

    assign lane_mask_o = mask_q;
    assign mask_idle_o = ~|mask_q;

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf_o |-> lane_mask_o == $past(lane_mask_o));

    // R6
    udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_udf_o |-> lane_mask_o == $past(lane_mask_o));

    // R10
    push_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_push_i && !full) |=> (lane_mask_o & ~$past(lane_mask_o)) == '0);

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stack_ovf_o && stack_udf_o));
endmodule

// File: tb/simt_mask_stack_test.sv
module simt_mask_stack_test;
    localparam int LANES = 32;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push = 1'b0, flip = 1'b0, join_e = 1'b0;
    logic [LANES-1:0] pred = '0;
    logic [LANES-1:0] mask;
    logic             idle, ovf, udf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [LANES-1:0] m_stk [DEPTH];
    int               m_lvl;
    logic [LANES-1:0] m_mask;
    logic             m_ovf, m_udf;

    always #2 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_push_i   (push),
        .br_flip_i   (flip),
        .br_join_i   (join_e),
        .lane_pred_i (pred),
        .lane_mask_o (mask),
        .mask_idle_o (idle),
        .stack_ovf_o (ovf),
        .stack_udf_o (udf)
    );

    function automatic logic exp_idle(input logic [LANES-1:0] m);
        return (m == '0);
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model step; push first, then flip, then join.
    task automatic model(input logic p, input logic f, input logic j, input logic [LANES-1:0] pr);
        m_ovf = 1'b0;
        m_udf = 1'b0;
        if (p) begin
            if (m_lvl == DEPTH) m_ovf = 1'b1;
            else begin
                m_stk[m_lvl] = m_mask;
                m_lvl++;
                m_mask = m_mask & pr;
            end
        end else if (f) begin
            if (m_lvl == 0) m_udf = 1'b1;
            else m_mask = m_stk[m_lvl-1] & ~m_mask;
        end else if (j) begin
            if (m_lvl == 0) m_udf = 1'b1;
            else begin
                m_lvl--;
                m_mask = m_stk[m_lvl];
            end
        end
    endtask

    // Drive one cycle at a falling edge, compare at the next falling edge.
    task automatic step(input string req, input logic p, input logic f, input logic j,
                        input logic [LANES-1:0] pr);
        push = p; flip = f; join_e = j; pred = pr;
        model(p, f, j, pr);
        @(negedge clk);
        push = 1'b0; flip = 1'b0; join_e = 1'b0;
        chk({req, " mask"}, mask, m_mask);
        chk({req, " R7 ovf"}, LANES'(ovf), LANES'(m_ovf));
        chk({req, " R7 udf"}, LANES'(udf), LANES'(m_udf));
        chk({req, " R8 idle"}, LANES'(idle), LANES'(exp_idle(m_mask)));
    endtask

    initial begin
        void'($urandom(32'd7351));
        m_lvl = 0; m_mask = '1; m_ovf = 1'b0; m_udf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", mask, '1);
        chk("R1 flags", LANES'({ovf, udf, idle}), '0);
        step("R1 R6 empty join", 1'b0, 1'b0, 1'b1, '0);
        step("R6 empty flip", 1'b0, 1'b1, 1'b0, '0);
        // R2 nested pushes to full, then R5 overflow
        step("R2 push", 1'b1, 1'b0, 1'b0, 32'h0000_FFFF);
        step("R3 flip", 1'b0, 1'b1, 1'b0, '0);
        step("R3 flip back", 1'b0, 1'b1, 1'b0, '0);
        step("R2 push", 1'b1, 1'b0, 1'b0, 32'h00FF_00FF);
        step("R2 push", 1'b1, 1'b0, 1'b0, 32'h0F0F_0F0F);
        step("R10 flip nested", 1'b0, 1'b1, 1'b0, '0);
        step("R8 push zero", 1'b1, 1'b0, 1'b0, '0);
        step("R5 overflow", 1'b1, 1'b0, 1'b0, '1);
        step("R7 quiet", 1'b0, 1'b0, 1'b0, '0);
        step("R9 push wins", 1'b1, 1'b1, 1'b1, '1);
        step("R9 flip wins", 1'b0, 1'b1, 1'b1, '0);
        for (int i = 0; i < DEPTH; i++) step("R4 join", 1'b0, 1'b0, 1'b1, '0);
        step("R4 R1 restored", 1'b0, 1'b0, 1'b0, '0);
        chk("R4 all ones", mask, '1);
        step("R6 underflow", 1'b0, 1'b0, 1'b1, '0);
        // Random mix, predicates biased toward few set bits at times
        for (int n = 0; n < 4000; n++) begin
            logic [LANES-1:0] pr;
            int sel;
            sel = $urandom_range(0, 9);
            pr = $urandom();
            if (sel == 9) pr = pr & $urandom() & $urandom();
            step("R2 R3 R4 R9 R10 random",
                 sel < 4, (sel == 4 || sel == 5 || sel == 8), (sel >= 6 && sel <= 8), pr);
        end
        summary();
    end
endmodule